// File: doc/BRIEF.md
# E3 Alignment-Signal Error Injector

This block sits on a serial E3 bit stream after the frame generator and deliberately damages the 10-bit frame alignment word so that a far-end receiver's framing logic can be tested. Each beat of the stream carries one data bit, a valid flag and a frame-start flag. The frame-start flag marks the first alignment bit. Every bit outside the alignment word passes through unchanged. This includes the alarm bit, the national-use bit and the payload.

A request can come from a one-cycle register pulse or from an asynchronous manual-insert pin, and a configuration bit selects which source is honoured. Two corruption kinds are available, each with its own enable. One kind inverts a single alignment bit. The other inverts the whole word, so that 0000101111 goes out in place of 1111010000. A request corrupts either one frame or a run of four consecutive frames. Corruption always starts at the next frame-start after the request has been taken. The stream, with its flags, leaves the block one clock after it enters.

Top module: `e3_fas_err_inject`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, out_sof and out_data are all 0.
- R2: out_valid, out_sof and out_data follow in_valid, in_sof and the (possibly corrupted) in_data with exactly one clock of latency.
- R3: Frame bits 10 and above (alarm bit, national-use bit, payload) are never altered. Frames that have no accepted request pending for them pass unaltered.
- R4: With cfg_kind=0 (single-bit kind), a corrupted frame has only frame bit 0, the first alignment bit sent, inverted.
- R5: With cfg_kind=1 (whole-word kind), a corrupted frame has all ten alignment bits (frame bits 0 to 9) inverted, so that 1111010000 is sent as 0000101111, first bit first.
- R6: An accepted request takes effect at the next frame-start beat and never on the frame that is in progress. This holds even when the request arrives inside a clean alignment word.
- R7: With cfg_burst=0, one request corrupts exactly one frame.
- R8: With cfg_burst=1, one request corrupts exactly four consecutive frames, and the fifth frame is clean.
- R9: With cfg_src_pin=0, only reg_req pulses are requests. With cfg_src_pin=1, only rising edges of man_req are requests.
- R10: man_req is synchronised and edge-detected, so a level held high over several frames counts as one request.
- R11: A request whose selected kind has its enable (cfg_one_en for kind 0, cfg_all_en for kind 1) at 0 is dropped and corrupts nothing.
- R12: A request is ignored if it arrives while a burst still has frames to go, or during the alignment word of a frame that is being corrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src_pin | input | 1 | 1 selects the manual pin as request source, 0 selects reg_req |
| cfg_kind | input | 1 | 0 selects single-bit corruption, 1 selects whole-word corruption |
| cfg_burst | input | 1 | 1 corrupts four frames per request, 0 corrupts one |
| cfg_one_en | input | 1 | Enables the single-bit kind |
| cfg_all_en | input | 1 | Enables the whole-word kind |
| reg_req | input | 1 | One-cycle request pulse from a register |
| man_req | input | 1 | Asynchronous manual request pin; a rising edge is a request |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | Input beat is frame bit 0 |
| in_data | input | 1 | Input stream bit |
| out_valid | output | 1 | Output beat valid |
| out_sof | output | 1 | Output beat is frame bit 0 |
| out_data | output | 1 | Output stream bit |

## Verification
Every output beat is due exactly one clock after its input beat. The bench drives on the falling edge and compares the previous beat's expected valid, frame-start and data values at the next falling edge, after the single output register has been loaded. The effect of a request is due only in the frame after it. Requests are placed well inside a frame, and the check is made on the whole following frame or frames. A manual-pin request passes through two synchroniser stages and an edge register before it is taken, so the bench raises the pin at least twelve beats before the next frame-start.

// File: rtl/e3fi_pkg.sv
`timescale 1ns/1ps
package e3fi_pkg;
  typedef enum logic {
    ERR_ONE_BIT  = 1'b0,
    ERR_ALL_BITS = 1'b1
  } err_kind_e;
endpackage

// File: rtl/e3fi_req_front.sv
`timescale 1ns/1ps
module e3fi_req_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_pin,
  input  logic reg_pulse,
  input  logic pin_async,
  output logic req
);
  localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SW-1:0] sync_q, sync_n;
  logic          last_q, last_n;
  logic          pin_s;
  logic          pin_rise;

  always_comb begin
    sync_n = {sync_q[SW-2:0], pin_async};
    pin_s  = sync_q[SW-1];
    last_n = pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
      last_q <= last_n;
    end
  end

  assign pin_rise = pin_s & ~last_q;
  assign req      = sel_pin ? pin_rise : reg_pulse;
endmodule

// File: rtl/e3fi_fas_pos.sv
`timescale 1ns/1ps
module e3fi_fas_pos #(
  parameter int FAS_LEN = 10,
  localparam int POS_W  = $clog2(FAS_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_valid,
  input  logic             beat_sof,
  output logic [POS_W-1:0] pos_cur,
  output logic             in_fas
);
  localparam logic [POS_W-1:0] POS_END = POS_W'(FAS_LEN);

  logic [POS_W-1:0] pos_q, pos_n;

  always_comb begin
    pos_cur = beat_sof ? '0 : pos_q;
    in_fas  = beat_valid & (pos_cur < POS_END);
    pos_n   = pos_q;
    if (beat_valid) begin
      pos_n = (pos_cur == POS_END) ? pos_cur : pos_cur + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= POS_END;
    else        pos_q <= pos_n;
  end
endmodule

// File: rtl/e3fi_sched.sv
`timescale 1ns/1ps
module e3fi_sched
  import e3fi_pkg::*;
#(
  parameter int BURST_LEN = 4,
  localparam int CNT_W    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  err_kind_e        req_kind,
  input  logic             req_burst,
  input  logic             one_en,
  input  logic             all_en,
  input  logic             beat_valid,
  input  logic             beat_sof,
  input  logic             in_fas,
  output logic             hit,
  output err_kind_e        hit_kind,
  output logic             busy,
  output logic             pend,
  output logic [CNT_W-1:0] rem
);
  localparam logic [CNT_W-1:0] REM_RELOAD = CNT_W'(BURST_LEN - 1);

  logic             pend_q, pend_n;
  logic             hit_q, hit_n;
  logic             burst_q, burst_n;
  err_kind_e        kind_q, kind_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic             sof_beat, start, kind_ok, accept;

  always_comb begin
    sof_beat = beat_valid & beat_sof;
    start    = sof_beat & (pend_q | (rem_q != '0));
    hit      = sof_beat ? start : hit_q;
    busy     = (rem_q != '0) | (hit & in_fas);
    kind_ok  = (req_kind == ERR_ONE_BIT) ? one_en : all_en;
    accept   = req & kind_ok & ~pend_q & ~busy;

    hit_n    = hit;
    pend_n   = accept | (pend_q & ~sof_beat);
    kind_n   = accept ? req_kind  : kind_q;
    burst_n  = accept ? req_burst : burst_q;
    rem_n    = rem_q;
    if (start) begin
      if (rem_q != '0) rem_n = rem_q - 1'b1;
      else             rem_n = burst_q ? REM_RELOAD : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      hit_q   <= 1'b0;
      burst_q <= 1'b0;
      kind_q  <= ERR_ONE_BIT;
      rem_q   <= '0;
    end else begin
      pend_q  <= pend_n;
      hit_q   <= hit_n;
      burst_q <= burst_n;
      kind_q  <= kind_n;
      rem_q   <= rem_n;
    end
  end

  assign hit_kind = kind_q;
  assign pend     = pend_q;
  assign rem      = rem_q;
endmodule

// File: rtl/e3_fas_err_inject.sv
`timescale 1ns/1ps
module e3_fas_err_inject
  import e3fi_pkg::*;
#(
  parameter int FAS_LEN     = 10,
  parameter int BIT_POS     = 0,
  parameter int BURST_LEN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_src_pin,
  input  logic cfg_kind,
  input  logic cfg_burst,
  input  logic cfg_one_en,
  input  logic cfg_all_en,
  input  logic reg_req,
  input  logic man_req,
  input  logic in_valid,
  input  logic in_sof,
  input  logic in_data,
  output logic out_valid,
  output logic out_sof,
  output logic out_data
);
  localparam int POS_W = $clog2(FAS_LEN + 1);
  localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [POS_W-1:0] ONE_POS = POS_W'(BIT_POS);

  logic             req;
  logic [POS_W-1:0] pos_cur;
  logic             fas_win;
  logic             hit;
  err_kind_e        hit_kind;
  logic             sched_busy;
  logic             sched_pend;
  logic [CNT_W-1:0] sched_rem;
  logic             flip;
  logic             valid_n, sof_n, data_n;

  e3fi_req_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_pin   (cfg_src_pin),
    .reg_pulse (reg_req),
    .pin_async (man_req),
    .req       (req)
  );

  e3fi_fas_pos #(.FAS_LEN(FAS_LEN)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (in_valid),
    .beat_sof   (in_sof),
    .pos_cur    (pos_cur),
    .in_fas     (fas_win)
  );

  e3fi_sched #(.BURST_LEN(BURST_LEN)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .req_kind   (err_kind_e'(cfg_kind)),
    .req_burst  (cfg_burst),
    .one_en     (cfg_one_en),
    .all_en     (cfg_all_en),
    .beat_valid (in_valid),
    .beat_sof   (in_sof),
    .in_fas     (fas_win),
    .hit        (hit),
    .hit_kind   (hit_kind),
    .busy       (sched_busy),
    .pend       (sched_pend),
    .rem        (sched_rem)
  );

  always_comb begin
    flip    = hit & fas_win &
              ((hit_kind == ERR_ALL_BITS) | (pos_cur == ONE_POS));
    valid_n = in_valid;
    sof_n   = in_sof;
    data_n  = in_data ^ flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_data  <= 1'b0;
    end else begin
      out_valid <= valid_n;
      out_sof   <= sof_n;
      out_data  <= data_n;
    end
  end
endmodule

// File: rtl/e3fi_chk.sv
`timescale 1ns/1ps
module e3fi_chk
  import e3fi_pkg::*;
#(
  parameter int POS_W   = 4,
  parameter int CNT_W   = 2,
  parameter int BIT_POS = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_data,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_data,
  input logic             fas_win,
  input logic [POS_W-1:0] pos_cur,
  input logic             flip,
  input err_kind_e        hit_kind,
  input logic             busy,
  input logic             pend,
  input logic [CNT_W-1:0] rem
);
  // R2
  fwd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R2
  fwd_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_sof == $past(in_sof)));

  // R3
  payload_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fas_win) |=> (out_data == $past(in_data)));

  // R4
  one_bit_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && hit_kind == ERR_ONE_BIT) |-> (pos_cur == POS_W'(BIT_POS)));

  // R12
  busy_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pend) |=> !pend);

  // R12
  burst_excl_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rem != '0) |-> !pend);
endmodule

bind e3_fas_err_inject e3fi_chk #(
  .POS_W   (POS_W),
  .CNT_W   (CNT_W),
  .BIT_POS (BIT_POS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sof    (in_sof),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_data  (out_data),
  .fas_win   (fas_win),
  .pos_cur   (pos_cur),
  .flip      (flip),
  .hit_kind  (hit_kind),
  .busy      (sched_busy),
  .pend      (sched_pend),
  .rem       (sched_rem)
);

// File: tb/sim_e3_fas_err_inject.sv
`timescale 1ns/1ps
module sim_e3_fas_err_inject;
  localparam int FRAME = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cfg_src_pin, cfg_kind, cfg_burst, cfg_one_en, cfg_all_en;
  logic reg_req, man_req, in_valid, in_sof, in_data;
  logic out_valid, out_sof, out_data;

  e3_fas_err_inject u0 (
    .clk(clk), .rst_n(rst_n), .cfg_src_pin(cfg_src_pin), .cfg_kind(cfg_kind),
    .cfg_burst(cfg_burst), .cfg_one_en(cfg_one_en), .cfg_all_en(cfg_all_en),
    .reg_req(reg_req), .man_req(man_req), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
  );

  int n_run = 0;
  int n_fail = 0;
  int fno = 0;
  bit done = 1'b0;
  bit have_prev = 1'b0;
  bit pv, ps, ped;
  bit frame_bad;
  logic [2:0] bad_act, bad_exp;

  function automatic bit fas_bit(int i);
    logic [9:0] pat = 10'b1111010000;
    return pat[9-i];
  endfunction

  function automatic bit pay_bit(int i, int f);
    return ((i * 5 + f * 3) % 7) < 3;
  endfunction

  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // pin_cmd: -1 leave man_req, 0 drive low, 1 drive high
  task automatic beat(bit v, bit s, bit d, bit ed, bit rq, int pin_cmd);
    logic [2:0] act, exp;
    @(negedge clk);
    if (have_prev) begin
      act = {out_valid, out_sof, pv ? out_data : 1'b0};
      exp = {pv, ps, ped};
      if (act !== exp) begin
        if (!frame_bad) begin
          bad_act = act;
          bad_exp = exp;
        end
        frame_bad = 1'b1;
      end
    end
    in_valid = v;
    in_sof   = s;
    in_data  = d;
    reg_req  = rq;
    if (pin_cmd == 0) man_req = 1'b0;
    if (pin_cmd == 1) man_req = 1'b1;
    pv = v;
    ps = s;
    ped = v ? ed : 1'b0;
    have_prev = 1'b1;
  endtask

  // kind: 0 clean, 1 bit 0 inverted, 2 bits 0..9 inverted
  task automatic send_frame(string tag, int kind, int reg_at, int pin_up, int pin_down);
    frame_bad = 1'b0;
    bad_act = '0;
    bad_exp = '0;
    for (int i = 0; i < FRAME; i++) begin
      bit d, ed;
      int pc;
      d  = (i < 10) ? fas_bit(i) : pay_bit(i, fno);
      ed = d ^ ((kind == 1 && i == 0) || (kind == 2 && i < 10));
      pc = (i == pin_up) ? 1 : ((i == pin_down) ? 0 : -1);
      beat(1'b1, i == 0, d, ed, i == reg_at, pc);
    end
    beat(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    check(!frame_bad, $sformatf("%s (frame %0d, {valid,sof,data})", tag, fno),
          32'(bad_act), 32'(bad_exp));
    fno++;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cfg_src_pin = 1'b0; cfg_kind = 1'b0; cfg_burst = 1'b0;
    cfg_one_en = 1'b1; cfg_all_en = 1'b1;
    reg_req = 1'b0; man_req = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_data = 1'b0;
    repeat (3) @(negedge clk);
    check({out_valid, out_sof, out_data} === 3'b000, "R1 outputs during reset",
          32'({out_valid, out_sof, out_data}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({out_valid, out_sof, out_data} === 3'b000, "R1 outputs after reset",
          32'({out_valid, out_sof, out_data}), 0);
  endtask

  task automatic t_clean;
    send_frame("R2 R3 clean stream", 0, -1, -1, -1);
    send_frame("R2 R3 clean stream", 0, -1, -1, -1);
  endtask

  task automatic t_one_bit;
    cfg_kind = 1'b0;
    send_frame("R6 request frame stays clean", 0, 15, -1, -1);
    send_frame("R4 single bit inverted", 1, -1, -1, -1);
    send_frame("R7 single mode one frame only", 0, -1, -1, -1);
  endtask

  task automatic t_all_bits;
    cfg_kind = 1'b1;
    send_frame("R6 request frame stays clean", 0, 15, -1, -1);
    send_frame("R5 whole word inverted", 2, 4, -1, -1);
    send_frame("R12 request in corrupted FAS ignored", 0, 4, -1, -1);
    send_frame("R6 mid-FAS request lands next frame", 2, -1, -1, -1);
    send_frame("R7 whole word one frame only", 0, -1, -1, -1);
    cfg_kind = 1'b0;
  endtask

  task automatic t_burst;
    cfg_burst = 1'b1;
    cfg_kind = 1'b0;
    send_frame("R8 burst request frame clean", 0, 15, -1, -1);
    send_frame("R8 burst frame 1", 1, -1, -1, -1);
    send_frame("R8 burst frame 2", 1, 15, -1, -1);
    send_frame("R8 burst frame 3", 1, -1, -1, -1);
    send_frame("R8 burst frame 4", 1, -1, -1, -1);
    send_frame("R8 R12 fifth frame clean", 0, -1, -1, -1);
    cfg_burst = 1'b0;
  endtask

  task automatic t_enable;
    cfg_kind = 1'b0; cfg_one_en = 1'b0;
    send_frame("R11 disabled single-bit request", 0, 15, -1, -1);
    send_frame("R11 disabled single-bit no effect", 0, -1, -1, -1);
    cfg_one_en = 1'b1;
    cfg_kind = 1'b1; cfg_all_en = 1'b0;
    send_frame("R11 disabled whole-word request", 0, 15, -1, -1);
    send_frame("R11 disabled whole-word no effect", 0, -1, -1, -1);
    cfg_all_en = 1'b1;
    cfg_kind = 1'b0;
  endtask

  task automatic t_source;
    cfg_src_pin = 1'b0;
    send_frame("R9 pin pulse while register selected", 0, -1, 5, 12);
    send_frame("R9 pin ignored", 0, -1, -1, -1);
    cfg_src_pin = 1'b1;
    send_frame("R9 register pulse while pin selected", 0, 15, -1, -1);
    send_frame("R9 register ignored", 0, -1, -1, -1);
    send_frame("R9 pin rise frame clean", 0, -1, 5, -1);
    send_frame("R9 R10 pin edge corrupts next frame", 1, -1, -1, -1);
    send_frame("R10 held pin is one request", 0, -1, -1, 3);
    send_frame("R10 pin release no request", 0, -1, -1, -1);
    cfg_src_pin = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_clean();
    t_one_bit();
    t_all_bits();
    t_burst();
    t_enable();
    t_source();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule